// File: doc/BRIEF.md
# Console Bus Memory Map Decoder

This block sits on the processor side of a small console system and turns each 16-bit bus address into an access to one of two memories: a byte-wide work RAM and a read-only program image. The work RAM appears at the bottom of the address space and repeats throughout a low window. The program image is fixed when the design is elaborated. It occupies the whole upper half of the space, and it repeats as many times as needed to fill that half. The last six bytes of the image hold three little-endian vectors that the processor fetches after an interrupt or a reset.

Reads are purely combinational from the address. A RAM write lands on the rising clock edge where both the cycle enable and the write strobe are high. Writes aimed at the program window are dropped. Any address that falls between the RAM window and the program window reads as zero. When such an access is made with the cycle enable high, the block raises a one-cycle error pulse.

Top module: `bus_map_decoder`

## Requirements
- R1: An address below RAM_WINDOW reads the RAM byte at index (address mod RAM_BYTES), so every copy of the RAM inside the window shows the same data.
- R2: With cyc_en_i and wr_i both high and the address in the RAM window, wdata_i is stored on that rising edge and is visible on rdata_o straight after that edge.
- R3: A write with cyc_en_i low changes no RAM byte.
- R4: An address with bit 15 set reads program byte P[(address − 0x8000) mod ROM_BYTES]. For an offset o outside the last six bytes, P[o] = o[7:0] XOR o[15:8] XOR ROM_SEED.
- R5: Program offsets ROM_BYTES−6/−5 hold NMI_VEC (low byte first), −4/−3 hold RST_VEC, and −2/−1 hold IRQ_VEC. They therefore read back at 0xFFFA through 0xFFFF.
- R6: A write anywhere in 0x8000–0xFFFF changes neither the program bytes nor any RAM byte.
- R7: Addresses from RAM_WINDOW up to 0x7FFF read 0x00.
- R8: unmapped_o is high for exactly the one cycle after a rising edge where cyc_en_i was high and the address was in the unmapped gap, whether the access was a read or a write. At all other times it is low.
- R9: A write into the unmapped gap changes no RAM byte.
- R10: unmapped_o is low while rst_ni is low and in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset of the error flag |
| cyc_en_i | input | 1 | Bus cycle enable; qualifies writes and the error flag |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe (1 = write, 0 = read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| unmapped_o | output | 1 | One-cycle pulse after an enabled access to the unmapped gap |

## Verification
The bench builds the block with a 256-byte RAM, a 1 KiB RAM window and a 1 KiB program image. With these sizes the RAM repeats four times and the program image repeats thirty-two times. That makes a full sweep of all 65536 addresses cheap, and the sweep checks every mirror, both window boundaries and the vector bytes against arithmetic expectations. The RAM is filled through rotating mirror addresses before the sweep, so a fault in the index bits shows up as a wrong byte. Dropped writes are then tested at aliases that would hit filled RAM cells.

// File: rtl/bus_map_pkg.sv
package bus_map_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2
    } region_e;

    typedef struct packed {
        logic unmapped;
    } flag_state_t;

endpackage

// File: rtl/map_region_decode.sv
module map_region_decode
    import bus_map_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RAM_BYTES  = 2048,
    parameter int RAM_WINDOW = 8192,
    parameter int ROM_BYTES  = 16384,
    parameter int ROM_BASE   = 32768
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             addr_i,
    output region_e                       region_o,
    output logic [$clog2(RAM_BYTES)-1:0]  ram_idx_o,
    output logic [$clog2(ROM_BYTES)-1:0]  rom_off_o
);
    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam int ROM_AW = $clog2(ROM_BYTES);
    localparam logic [ADDR_W-1:0] RAM_LIMIT = ADDR_W'(RAM_WINDOW);
    localparam logic [ADDR_W-1:0] ROM_START = ADDR_W'(ROM_BASE);

    always_comb begin
        if (addr_i >= ROM_START) begin
            region_o = RGN_ROM;
        end else if (addr_i < RAM_LIMIT) begin
            region_o = RGN_RAM;
        end else begin
            region_o = RGN_NONE;
        end
        // Both regions are power-of-two sized and aligned, so the
        // modulo reduces to keeping the low address bits.
        ram_idx_o = addr_i[RAM_AW-1:0];
        rom_off_o = addr_i[ROM_AW-1:0];
    end

    AST_ROM_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_i[ADDR_W-1] |-> (region_o == RGN_ROM));  // R4

    AST_LOW_PAGE_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i[ADDR_W-1:8] == '0) |-> (region_o == RGN_RAM));  // R1

endmodule

// File: rtl/map_rom_image.sv
module map_rom_image #(
    parameter int          ROM_BYTES = 16384,
    parameter logic [7:0]  ROM_SEED  = 8'h5A,
    parameter logic [15:0] NMI_VEC   = 16'h8010,
    parameter logic [15:0] RST_VEC   = 16'h8000,
    parameter logic [15:0] IRQ_VEC   = 16'h8020
) (
    input  logic [$clog2(ROM_BYTES)-1:0] off_i,
    output logic [7:0]                   data_o
);
    localparam int ROM_AW = $clog2(ROM_BYTES);
    localparam logic [ROM_AW-1:0] OFF_NMI_LO = ROM_AW'(ROM_BYTES - 6);
    localparam logic [ROM_AW-1:0] OFF_NMI_HI = ROM_AW'(ROM_BYTES - 5);
    localparam logic [ROM_AW-1:0] OFF_RST_LO = ROM_AW'(ROM_BYTES - 4);
    localparam logic [ROM_AW-1:0] OFF_RST_HI = ROM_AW'(ROM_BYTES - 3);
    localparam logic [ROM_AW-1:0] OFF_IRQ_LO = ROM_AW'(ROM_BYTES - 2);
    localparam logic [ROM_AW-1:0] OFF_IRQ_HI = ROM_AW'(ROM_BYTES - 1);

    logic [31:0] off_wide;

    always_comb begin
        off_wide = 32'(off_i);
        if (off_i == OFF_NMI_LO) begin
            data_o = NMI_VEC[7:0];
        end else if (off_i == OFF_NMI_HI) begin
            data_o = NMI_VEC[15:8];
        end else if (off_i == OFF_RST_LO) begin
            data_o = RST_VEC[7:0];
        end else if (off_i == OFF_RST_HI) begin
            data_o = RST_VEC[15:8];
        end else if (off_i == OFF_IRQ_LO) begin
            data_o = IRQ_VEC[7:0];
        end else if (off_i == OFF_IRQ_HI) begin
            data_o = IRQ_VEC[15:8];
        end else begin
            data_o = off_wide[7:0] ^ off_wide[15:8] ^ ROM_SEED;
        end
    end

endmodule

// File: rtl/map_ram_store.sv
module map_ram_store #(
    parameter int RAM_BYTES = 2048,
    parameter int DATA_W    = 8
) (
    input  logic                         clk_i,
    input  logic                         we_i,
    input  logic [$clog2(RAM_BYTES)-1:0] idx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o
);
    localparam int IDX_W = $clog2(RAM_BYTES);

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    wr_req_t           wr_d;
    logic [DATA_W-1:0] mem_q [RAM_BYTES];

    always_comb begin
        wr_d.en   = we_i;
        wr_d.idx  = idx_i;
        wr_d.data = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.data;
        end
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/bus_map_decoder.sv
module bus_map_decoder
    import bus_map_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          RAM_BYTES  = 2048,
    parameter int          RAM_WINDOW = 8192,
    parameter int          ROM_BYTES  = 16384,
    parameter int          ROM_BASE   = 32768,
    parameter logic [7:0]  ROM_SEED   = 8'h5A,
    parameter logic [15:0] NMI_VEC    = 16'h8010,
    parameter logic [15:0] RST_VEC    = 16'h8000,
    parameter logic [15:0] IRQ_VEC    = 16'h8020
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cyc_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              unmapped_o
);
    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    region_e           region;
    logic [RAM_AW-1:0] ram_idx;
    logic [ROM_AW-1:0] rom_off;
    logic [DATA_W-1:0] ram_rdata;
    logic [7:0]        rom_rdata;
    logic              ram_we;
    flag_state_t       st_d, st_q;

    map_region_decode #(
        .ADDR_W     (ADDR_W),
        .RAM_BYTES  (RAM_BYTES),
        .RAM_WINDOW (RAM_WINDOW),
        .ROM_BYTES  (ROM_BYTES),
        .ROM_BASE   (ROM_BASE)
    ) u_decode (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .region_o  (region),
        .ram_idx_o (ram_idx),
        .rom_off_o (rom_off)
    );

    map_ram_store #(
        .RAM_BYTES (RAM_BYTES),
        .DATA_W    (DATA_W)
    ) u_ram (
        .clk_i   (clk_i),
        .we_i    (ram_we),
        .idx_i   (ram_idx),
        .wdata_i (wdata_i),
        .rdata_o (ram_rdata)
    );

    map_rom_image #(
        .ROM_BYTES (ROM_BYTES),
        .ROM_SEED  (ROM_SEED),
        .NMI_VEC   (NMI_VEC),
        .RST_VEC   (RST_VEC),
        .IRQ_VEC   (IRQ_VEC)
    ) u_rom (
        .off_i  (rom_off),
        .data_o (rom_rdata)
    );

    // Writes reach storage only inside the RAM window; program and
    // unmapped writes fall through here and are dropped.
    assign ram_we = cyc_en_i && wr_i && (region == RGN_RAM);

    always_comb begin
        case (region)
            RGN_RAM: rdata_o = ram_rdata;
            RGN_ROM: rdata_o = DATA_W'(rom_rdata);
            default: rdata_o = '0;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.unmapped = cyc_en_i && (region == RGN_NONE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unmapped_o = st_q.unmapped;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (region == RGN_NONE) |-> (rdata_o == '0));  // R7

    AST_UNMAPPED_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_en_i && region == RGN_NONE) |=> unmapped_o);  // R8

    AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cyc_en_i && region == RGN_NONE) |=> !unmapped_o);  // R8

    AST_ROM_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_en_i && wr_i && addr_i[ADDR_W-1]) |-> !ram_we);  // R6

    AST_RAM_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_en_i && wr_i && region == RGN_RAM) ##1 $stable(addr_i)
        |-> (rdata_o == $past(wdata_i)));  // R2

endmodule

// File: tb/bus_map_decoder_test.sv
`timescale 1ns/1ps
module bus_map_decoder_test;
    localparam int          RAM_B   = 256;
    localparam int          RAM_WIN = 1024;
    localparam int          ROM_B   = 1024;
    localparam logic [7:0]  SEED    = 8'hA7;
    localparam logic [15:0] NMI     = 16'h8123;
    localparam logic [15:0] RST     = 16'h8000;
    localparam logic [15:0] IRQ     = 16'h83C5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        unmapped;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ram_model [RAM_B];

    always #2.5 clk = ~clk;

    bus_map_decoder #(
        .RAM_BYTES  (RAM_B),
        .RAM_WINDOW (RAM_WIN),
        .ROM_BYTES  (ROM_B),
        .ROM_SEED   (SEED),
        .NMI_VEC    (NMI),
        .RST_VEC    (RST),
        .IRQ_VEC    (IRQ)
    ) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cyc_en_i   (cyc_en),
        .addr_i     (addr),
        .wr_i       (wr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .unmapped_o (unmapped)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%04h actual=%02h expected=%02h", req, addr, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_exp(input int off);
        if (off == ROM_B - 6) return NMI[7:0];
        if (off == ROM_B - 5) return NMI[15:8];
        if (off == ROM_B - 4) return RST[7:0];
        if (off == ROM_B - 3) return RST[15:8];
        if (off == ROM_B - 2) return IRQ[7:0];
        if (off == ROM_B - 1) return IRQ[15:8];
        return 8'(off) ^ 8'(off >> 8) ^ SEED;
    endfunction

    // Drive one access for one edge, then park the bus on a read of the same address.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; cyc_en = en;
        @(negedge clk);
        wr = 1'b0; cyc_en = 1'b0;
        #0.5;
    endtask

    task automatic probe_flag(input logic [15:0] a, input logic en, input logic w,
                              input logic exp, input string req);
        @(negedge clk);
        addr = a; cyc_en = en; wr = w; wdata = 8'hEE;
        @(negedge clk);
        cyc_en = 1'b0; wr = 1'b0;
        chk(req, {7'b0, unmapped}, {7'b0, exp});
        @(negedge clk);
        chk(req, {7'b0, unmapped}, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: flag low in reset and right after release
        repeat (3) @(negedge clk);
        chk("R10", {7'b0, unmapped}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {7'b0, unmapped}, 8'h00);

        // R1/R2: fill every RAM cell through rotating mirrors, read back at once
        for (int i = 0; i < RAM_B; i++) begin
            logic [7:0] v;
            v = 8'((i * 7 + 3) ^ 8'h3C);
            bus_write(16'(i + RAM_B * (i % (RAM_WIN / RAM_B))), v, 1'b1);
            ram_model[i] = v;
            chk("R2", rdata, v);
        end

        // R3: write with cycle enable low is ignored
        bus_write(16'h0005, 8'hFF ^ ram_model[5], 1'b0);
        chk("R3", rdata, ram_model[5]);

        // R6: program writes at aliases of filled RAM cells and of vectors
        bus_write(16'h8005, 8'h11, 1'b1);
        chk("R6", rdata, rom_exp(5));
        bus_write(16'hFFFC, 8'h22, 1'b1);
        chk("R6", rdata, rom_exp(ROM_B - 4));
        bus_write(16'hC010, 8'h33, 1'b1);
        chk("R6", rdata, rom_exp(16'hC010 % ROM_B));
        addr = 16'h0005; #1; chk("R6", rdata, ram_model[5]);
        addr = 16'h0010; #1; chk("R6", rdata, ram_model[16]);
        addr = 16'h00FC; #1; chk("R6", rdata, ram_model[252]);

        // R9: unmapped write does not reach RAM
        bus_write(16'h0405, 8'h44, 1'b1);
        chk("R7", rdata, 8'h00);
        addr = 16'h0005; #1; chk("R9", rdata, ram_model[5]);
        bus_write(16'h7FFF, 8'h55, 1'b1);
        addr = 16'h00FF; #1; chk("R9", rdata, ram_model[255]);

        // R8: error pulse behaviour
        probe_flag(16'h0400, 1'b1, 1'b0, 1'b1, "R8");
        probe_flag(16'h4000, 1'b1, 1'b1, 1'b1, "R8");
        probe_flag(16'h7FFF, 1'b1, 1'b0, 1'b1, "R8");
        probe_flag(16'h4000, 1'b0, 1'b0, 1'b0, "R8");
        probe_flag(16'h03FF, 1'b1, 1'b0, 1'b0, "R8");
        probe_flag(16'h8000, 1'b1, 1'b1, 1'b0, "R8");

        // R1/R4/R5/R7: full address sweep
        for (int a = 0; a < 65536; a++) begin
            @(negedge clk);
            addr = 16'(a);
            #1;
            if (a < RAM_WIN) begin
                chk("R1", rdata, ram_model[a % RAM_B]);
            end else if (a < 32768) begin
                chk("R7", rdata, 8'h00);
            end else if (a >= 16'hFFFA) begin
                chk("R5", rdata, rom_exp((a - 32768) % ROM_B));
            end else begin
                chk("R4", rdata, rom_exp((a - 32768) % ROM_B));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule